// File: doc/BRIEF.md
# Relocatable Resource Address Decoder

This block turns a 16-bit processor address into one select for each of three on-chip resources: a block of control registers, an SRAM and an EEPROM. A fourth select flags addresses that none of them claims, so that an external or default target can answer those. Each resource has a base register that sets where it sits in the 64 KB space, on any 2 KB boundary. A small write-only configuration bus moves a resource by loading a new base.

Decoding is combinational from the address and the stored bases. A base write is captured at the clock edge that ends the write cycle, so the new map applies from the next cycle on. Regions may overlap. The register block then wins over the other two, and the SRAM wins over the EEPROM. Along with the selects, the block outputs the address relative to the base of the selected resource. The EEPROM also has an enable bit and decodes only while that bit is set.

Top module: `rsrc_decoder`

## Requirements
- R1: After reset the register block base is 0x0000, the SRAM base is 0x0800, the EEPROM base is 0x1000 and the EEPROM enable is clear. The register block claims 0x0000–0x03FF, the SRAM claims 0x0800–0x17FF, and 0x0400 and 0x1800 are unclaimed.
- R2: A write with `cfgWe` high places `cfgWdata[5:1]` into address bits 15:11 of the base selected by `cfgSel` (0 = register block, 1 = SRAM, 2 = EEPROM). Any of the 32 2 KB-aligned bases can be reached this way.
- R3: The register block claims 2^REG_SIZE_LOG2 bytes from its base (1 KB by default). The byte just past the end is not claimed by the register block.
- R4: The SRAM claims 2^RAM_SIZE_LOG2 bytes from its base (4 KB by default).
- R5: The EEPROM claims 2^EE_SIZE_LOG2 bytes from its base (2 KB by default), and only while the enable bit, written from `cfgWdata[0]` on an EEPROM write, is 1.
- R6: During the cycle in which a base write is presented, decoding still uses the old base. From the next cycle on, it uses the new base.
- R7: Where the register block overlaps the SRAM or the EEPROM, the register block is selected.
- R8: Where the SRAM and the enabled EEPROM overlap and the register block does not claim the address, the SRAM is selected.
- R9: An address claimed by no resource asserts `selExt`. Exactly one of `selReg`, `selRam`, `selEe` and `selExt` is high at all times.
- R10: `offset` equals the address minus the base of the selected resource, or the address itself when `selExt` is high.
- R11: A write with `cfgSel` = 3 changes no base and no enable.
- R12: A region placed near the top of the space does not wrap: an SRAM at base 0xF800 claims nothing below 0xF800.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Base register write strobe |
| cfgSel | input | 2 | Target of the write: 0 register block, 1 SRAM, 2 EEPROM, 3 none |
| cfgWdata | input | 6 | [5:1] base address bits 15:11, [0] EEPROM enable |
| cpuAddr | input | 16 | Address to decode |
| selReg | output | 1 | Register block selected |
| selRam | output | 1 | SRAM selected |
| selEe | output | 1 | EEPROM selected |
| selExt | output | 1 | No on-chip resource claims the address |
| offset | output | 16 | Address relative to the selected base |

## Verification
The bench moves each resource through all 32 bases and probes the first and last byte of each window and the bytes on either side of it. A design with a bad size compare or a swapped base field would select the wrong target at those edges. Stacked overlaps catch a priority that lets the SRAM or EEPROM shadow the register block, or that lets the EEPROM shadow the SRAM. A probe of the base that is just being written catches a map that changes too early or too late. A top-of-space SRAM is probed to catch a range compare that wraps to low addresses. Writes to the unused target code, and a disabled EEPROM, are checked to show they leave the decode unchanged.

// File: rtl/rsrc_pkg.sv
package rsrc_pkg;

  typedef enum logic [1:0] {
    RSRC_REG  = 2'd0,
    RSRC_RAM  = 2'd1,
    RSRC_EE   = 2'd2,
    RSRC_NONE = 2'd3
  } rsrcSel_e;

  typedef struct packed {
    logic ldReg;
    logic ldRam;
    logic ldEe;
  } loadStrb_t;

endpackage

// File: rtl/rsrc_ctrl.sv
module rsrc_ctrl
  import rsrc_pkg::*;
(
  input  logic       cfgWe,
  input  logic [1:0] cfgSel,
  output loadStrb_t  strb
);

  always_comb begin
    strb = '0;
    if (cfgWe) begin
      unique case (rsrcSel_e'(cfgSel))
        RSRC_REG:  strb.ldReg = 1'b1;
        RSRC_RAM:  strb.ldRam = 1'b1;
        RSRC_EE:   strb.ldEe  = 1'b1;
        RSRC_NONE: strb       = '0;
        default:   strb       = '0;
      endcase
    end
  end

endmodule

// File: rtl/rsrc_datapath.sv
module rsrc_datapath
  import rsrc_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int GRAN_LOG2     = 11,
  parameter int REG_SIZE_LOG2 = 10,
  parameter int RAM_SIZE_LOG2 = 12,
  parameter int EE_SIZE_LOG2  = 11,
  parameter int REG_RST_BASE  = 0,
  parameter int RAM_RST_BASE  = 1,
  parameter int EE_RST_BASE   = 2,
  localparam int BASE_W = ADDR_W - GRAN_LOG2,
  localparam int DATA_W = BASE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  loadStrb_t         strb,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              selReg,
  output logic              selRam,
  output logic              selEe,
  output logic              selExt,
  output logic [ADDR_W-1:0] offset
);

  localparam int NUM_RES = 3;
  localparam int SPAN_W  = ADDR_W + 1;

  logic [BASE_W-1:0] baseQ [NUM_RES];
  logic              eeEnQ;
  logic [BASE_W-1:0] newBase;
  logic [ADDR_W-1:0] baseAddr [NUM_RES];
  logic [NUM_RES-1:0] hit;
  rsrcSel_e          winner;

  assign newBase = cfgWdata[DATA_W-1:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ[0] <= BASE_W'(REG_RST_BASE);
      baseQ[1] <= BASE_W'(RAM_RST_BASE);
      baseQ[2] <= BASE_W'(EE_RST_BASE);
      eeEnQ    <= 1'b0;
    end else begin
      if (strb.ldReg) baseQ[0] <= newBase;
      if (strb.ldRam) baseQ[1] <= newBase;
      if (strb.ldEe) begin
        baseQ[2] <= newBase;
        eeEnQ    <= cfgWdata[0];
      end
    end
  end

  for (genvar i = 0; i < NUM_RES; i++) begin : gRegion
    localparam int SZ_LOG2 = (i == 0) ? REG_SIZE_LOG2 :
                             (i == 1) ? RAM_SIZE_LOG2 : EE_SIZE_LOG2;
    logic [SPAN_W-1:0] loBound;
    logic [SPAN_W-1:0] hiBound;
    logic              inRange;

    assign baseAddr[i] = {baseQ[i], {GRAN_LOG2{1'b0}}};
    assign loBound     = {1'b0, baseAddr[i]};
    assign hiBound     = loBound + (SPAN_W'(1) << SZ_LOG2);
    assign inRange     = ({1'b0, cpuAddr} >= loBound) && ({1'b0, cpuAddr} < hiBound);

    if (i == 2) begin : gGated
      assign hit[i] = inRange & eeEnQ;
    end else begin : gPlain
      assign hit[i] = inRange;
    end
  end

  always_comb begin
    if (hit[0])      winner = RSRC_REG;
    else if (hit[1]) winner = RSRC_RAM;
    else if (hit[2]) winner = RSRC_EE;
    else             winner = RSRC_NONE;
  end

  always_comb begin
    selReg = (winner == RSRC_REG);
    selRam = (winner == RSRC_RAM);
    selEe  = (winner == RSRC_EE);
    selExt = (winner == RSRC_NONE);
    unique case (winner)
      RSRC_REG:  offset = cpuAddr - baseAddr[0];
      RSRC_RAM:  offset = cpuAddr - baseAddr[1];
      RSRC_EE:   offset = cpuAddr - baseAddr[2];
      default:   offset = cpuAddr;
    endcase
  end

  // R9: exactly one select
  assert_one_select_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones({selReg, selRam, selEe, selExt}) == 1);

  // R7: register block claim always wins
  assert_reg_priority_R7: assert property (@(posedge clk) disable iff (!rstN)
    hit[0] |-> selReg);

  // R5: disabled EEPROM never selected
  assert_ee_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    !eeEnQ |-> !selEe);

  // R6: the SRAM base loaded on a write is the written field, visible next cycle
  assert_remap_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldRam |=> baseQ[1] == $past(newBase));

  // R11: no load strobe leaves every base unchanged
  assert_no_load_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> ($stable(baseQ[0]) && $stable(baseQ[1]) &&
                      $stable(baseQ[2]) && $stable(eeEnQ)));

  // R3: register block offset stays inside its window
  assert_reg_offset_R3: assert property (@(posedge clk) disable iff (!rstN)
    selReg |-> ({1'b0, offset} < (SPAN_W'(1) << REG_SIZE_LOG2)));

endmodule

// File: rtl/rsrc_decoder.sv
module rsrc_decoder
  import rsrc_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int GRAN_LOG2     = 11,
  parameter int REG_SIZE_LOG2 = 10,
  parameter int RAM_SIZE_LOG2 = 12,
  parameter int EE_SIZE_LOG2  = 11,
  localparam int DATA_W = ADDR_W - GRAN_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              selReg,
  output logic              selRam,
  output logic              selEe,
  output logic              selExt,
  output logic [ADDR_W-1:0] offset
);

  loadStrb_t strb;

  rsrc_ctrl uCtrl (
    .cfgWe  (cfgWe),
    .cfgSel (cfgSel),
    .strb   (strb)
  );

  rsrc_datapath #(
    .ADDR_W        (ADDR_W),
    .GRAN_LOG2     (GRAN_LOG2),
    .REG_SIZE_LOG2 (REG_SIZE_LOG2),
    .RAM_SIZE_LOG2 (RAM_SIZE_LOG2),
    .EE_SIZE_LOG2  (EE_SIZE_LOG2),
    .REG_RST_BASE  (0),
    .RAM_RST_BASE  (1),
    .EE_RST_BASE   (2)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgWdata (cfgWdata),
    .cpuAddr  (cpuAddr),
    .selReg   (selReg),
    .selRam   (selRam),
    .selEe    (selEe),
    .selExt   (selExt),
    .offset   (offset)
  );

endmodule

// File: tb/tb_rsrc_decoder.sv
module tb_rsrc_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [5:0]  cfgWdata = 6'd0;
  logic [15:0] cpuAddr = 16'd0;
  logic        selReg, selRam, selEe, selExt;
  logic [15:0] offset;

  int nChecks = 0;
  int nFail   = 0;
  int mBase [3];
  bit mEn;
  int mSize [3] = '{1024, 4096, 2048};

  always #2 clk = ~clk;

  rsrc_decoder dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cpuAddr(cpuAddr), .selReg(selReg), .selRam(selRam), .selEe(selEe),
    .selExt(selExt), .offset(offset)
  );

  function automatic void model(input int a, output logic [3:0] expSel, output logic [15:0] expOff);
    int code = 3;
    expOff = a[15:0];
    for (int i = 0; i < 3; i++) begin
      int lo = mBase[i] * 2048;
      bit h = (a >= lo) && (a < lo + mSize[i]);
      if (i == 2) h = h && mEn;
      if (h && code == 3) begin
        code = i;
        expOff = 16'(a - lo);
      end
    end
    expSel = 4'b0001 << code;   // bit0 reg, bit1 ram, bit2 ee, bit3 ext
  endfunction

  task automatic chk(input string tag, input int a);
    logic [3:0]  expSel, gotSel;
    logic [15:0] expOff;
    cpuAddr = a[15:0];
    #1;
    model(a, expSel, expOff);
    gotSel = {selExt, selEe, selRam, selReg};
    nChecks++;
    if (gotSel !== expSel || offset !== expOff) begin
      nFail++;
      $display("FAIL %s addr=%h sel=%b exp=%b offset=%h exp=%h", tag, a[15:0], gotSel, expSel, offset, expOff);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [5:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = s; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (s != 2'd3) begin
      mBase[s] = int'(d[5:1]);
      if (s == 2'd2) mEn = d[0];
    end
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    mBase = '{0, 1, 2};
    mEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset map
    chk("R1", 16'h0000); chk("R1", 16'h03FF); chk("R1", 16'h0400);
    chk("R1", 16'h0800); chk("R1", 16'h1000); chk("R1", 16'h17FF);
    chk("R1", 16'h1800);

    // R5 EEPROM enable gate
    wr(2'd2, {5'd2, 1'b1});
    chk("R5", 16'h1800); chk("R5", 16'h1FFF); chk("R5", 16'h2000);
    wr(2'd2, {5'd2, 1'b0});
    chk("R5", 16'h1800);

    // R3 / R2 register block across all bases
    for (int b = 0; b < 32; b++) begin
      wr(2'd0, {b[4:0], 1'b0});
      chk("R3", b * 2048);
      chk("R3", b * 2048 + 1023);
      chk("R3", b * 2048 + 1024);
      chk("R2", b * 2048 + 2047);
    end
    wr(2'd0, {5'd0, 1'b0});

    // R4 / R12 SRAM across all bases
    for (int b = 0; b < 32; b++) begin
      wr(2'd1, {b[4:0], 1'b0});
      chk("R4", b * 2048);
      if (b * 2048 + 4095 < 65536) chk("R4", b * 2048 + 4095);
      else chk("R4", 65535);
      if (b * 2048 + 4096 < 65536) chk("R4", b * 2048 + 4096);
      if (b > 0) chk("R2", b * 2048 - 1);
    end
    chk("R12", 16'h0400); chk("R12", 16'h07FF); chk("R12", 16'hF7FF);

    // R5 EEPROM across all bases, enabled
    for (int b = 0; b < 32; b++) begin
      wr(2'd2, {b[4:0], 1'b1});
      chk("R5", b * 2048);
      chk("R5", b * 2048 + 2047);
      if (b < 31) chk("R5", b * 2048 + 2048);
      if (b > 0) chk("R5", b * 2048 - 1);
    end

    // R7 / R8 overlaps
    wr(2'd0, {5'd8, 1'b0});
    wr(2'd1, {5'd8, 1'b0});
    wr(2'd2, {5'd8, 1'b1});
    chk("R7", 16'h4000); chk("R7", 16'h43FF);
    chk("R8", 16'h4400); chk("R8", 16'h47FF);
    wr(2'd2, {5'd9, 1'b1});
    chk("R8", 16'h4800); chk("R8", 16'h4FFF);
    wr(2'd0, {5'd9, 1'b0});
    chk("R7", 16'h4800); chk("R7", 16'h4BFF); chk("R8", 16'h4C00);
    wr(2'd1, {5'd10, 1'b0});
    chk("R10", 16'h4C05); chk("R10", 16'h5123); chk("R9", 16'h4000);

    // R6 one-cycle latency
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 2'd1; cfgWdata = {5'd20, 1'b0};
    chk("R6", 16'hA000);
    @(negedge clk);
    cfgWe = 1'b0;
    mBase[1] = 20;
    chk("R6", 16'hA000); chk("R10", 16'hA7FE);

    // R11 writes to unused code ignored
    wr(2'd3, {5'd31, 1'b1});
    chk("R11", 16'hA000); chk("R11", 16'h4800); chk("R11", 16'h4800 - 1);
    chk("R11", 16'hF800);

    // R9 unclaimed addresses
    chk("R9", 16'h0000); chk("R9", 16'hFFFF); chk("R9", 16'h2345);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule